// File: doc/BRIEF.md
# Go-back-N Sliding-Window Sender Controller

This block is the transmit-side control logic of a reliable link that recovers from errors by going back and resending. It assigns each outgoing protocol data unit (PDU) a sequence number that counts modulo 2^SEQ_W. It never lets more than WIN PDUs be outstanding without acknowledgement. It takes in cumulative receive-ready (RR) and reject (REJ) acknowledgements from the far end and moves its send pointer back when the far end asks for PDUs to be sent again.

The framer upstream raises `send_req_i` whenever it could put a PDU on the line. In the same cycle the controller answers with `send_gnt_o`, the sequence number to use, and a flag that says whether this is a retransmission of a buffered PDU or a fresh one. An acknowledgement timer watches the oldest outstanding PDU. When it runs out, the controller does not resend anything on its own. Instead it pulses `poll_cmd_o`, which asks the framer to send an RR command with the poll bit set, and then waits under a separate poll timer. It repeats the poll each time that timer expires. The far end's RR reply, or a REJ, ends the wait and sets the point from which sending resumes.

Top module: `gbn_tx_ctrl`

## Requirements
- R1: After reset, new PDUs are granted with sequence numbers 0, 1, 2, … wrapping modulo 2^SEQ_W (8 by default), each with `send_retx_o` low.
- R2: No new PDU is granted while WIN (7 by default) PDUs are outstanding. Outstanding means granted and not yet covered by an accepted acknowledgement.
- R3: An accepted RR carrying number n acknowledges every outstanding PDU before n. This frees that many window slots, so an earlier RR that was lost costs nothing.
- R4: After an accepted REJ carrying n, the following grants resend n, n+1, … with `send_retx_o` high until every previously granted number has been resent. After that, new grants resume with `send_retx_o` low.
- R5: An acknowledgement is accepted only if its number lies, counting forward modulo 2^SEQ_W, between the oldest outstanding number and the next new number, both inclusive. Any other acknowledgement changes neither the window nor the send pointer.
- R6: If no acknowledgement is accepted and PDUs stay outstanding, `poll_cmd_o` pulses high for one cycle exactly ACK_TMO clock edges after the oldest PDU became outstanding or the last acknowledgement was accepted, whichever is later.
- R7: While a poll is pending and no acknowledgement is accepted, `poll_cmd_o` pulses again every POLL_TMO clock edges.
- R8: While a poll is pending, `send_gnt_o` stays low even when `send_req_i` is high.
- R9: An accepted RR or REJ carrying n ends a pending poll. The next grant is then a retransmission of n.
- R10: `send_gnt_o` stays low in any cycle in which `ack_vld_i` is high, and that cycle consumes no sequence number.
- R11: An accepted RR whose number lies beyond the current retransmit point moves that point up to the RR's number, so PDUs that are already acknowledged are never resent.
- R12: With nothing outstanding, no poll is issued however long the block sits idle, and no grant is given without `send_req_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| send_req_i | input | 1 | Framer can transmit a PDU this cycle |
| send_gnt_o | output | 1 | PDU transmission granted this cycle |
| send_seq_o | output | SEQ_W | Sequence number of the granted PDU |
| send_retx_o | output | 1 | Granted PDU is a retransmission |
| ack_vld_i | input | 1 | Acknowledgement present this cycle |
| ack_rej_i | input | 1 | Acknowledgement kind: 0 = RR, 1 = REJ |
| ack_num_i | input | SEQ_W | Number carried by the acknowledgement |
| poll_cmd_o | output | 1 | One-cycle request to send an RR command with poll bit set |

## Verification
The hardest states to reach are the poll-pending ones: the far end must stay silent for a full acknowledgement timeout while PDUs are outstanding, and then the poll must be repeated and answered. The stimulus reaches them by granting a PDU and withholding every acknowledgement. It counts clock edges up to the first poll pulse and then up to the second. Only after that does it answer with an RR or a REJ and check where retransmission restarts. A sweep runs the window through all eight starting offsets so that the full-window limit and the cumulative acknowledgements are checked across the wrap of the sequence space.

// File: rtl/gbn_pkg.sv
package gbn_pkg;

    typedef enum logic [1:0] {
        GK_NONE = 2'd0,
        GK_NEW  = 2'd1,
        GK_RETX = 2'd2
    } grant_kind_e;

endpackage

// File: rtl/gbn_tmr.sv
module gbn_tmr #(
    parameter int LEN = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic clr_i,
    output logic exp_o
);
    localparam int W = $clog2(LEN + 1);
    localparam logic [W-1:0] LAST = W'(LEN - 1);

    logic [W-1:0] cnt_d, cnt_q;

    assign exp_o = run_i && !clr_i && (cnt_q == LAST);

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i || exp_o) begin
            cnt_d = '0;
        end else if (run_i) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R6 / R7: count never passes the expiry value
    a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

endmodule

// File: rtl/gbn_ack_window.sv
module gbn_ack_window #(
    parameter int SEQ_W = 3
) (
    input  logic [SEQ_W-1:0] base_i,
    input  logic [SEQ_W-1:0] nsend_i,
    input  logic [SEQ_W-1:0] nnew_i,
    input  logic [SEQ_W-1:0] num_i,
    output logic             accept_o,
    output logic             skip_o
);
    logic [SEQ_W-1:0] off_num, off_new, off_snd;

    always_comb begin
        off_num  = num_i - base_i;
        off_new  = nnew_i - base_i;
        off_snd  = nsend_i - base_i;
        accept_o = (off_num <= off_new);
        skip_o   = (off_snd < off_num);
    end

endmodule

// File: rtl/gbn_tx_ctrl.sv
module gbn_tx_ctrl
    import gbn_pkg::*;
#(
    parameter int SEQ_W    = 3,
    parameter int WIN      = 7,
    parameter int ACK_TMO  = 64,
    parameter int POLL_TMO = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             send_req_i,
    output logic             send_gnt_o,
    output logic [SEQ_W-1:0] send_seq_o,
    output logic             send_retx_o,
    input  logic             ack_vld_i,
    input  logic             ack_rej_i,
    input  logic [SEQ_W-1:0] ack_num_i,
    output logic             poll_cmd_o
);
    localparam logic [SEQ_W-1:0] WIN_V = SEQ_W'(WIN);

    typedef struct packed {
        logic [SEQ_W-1:0] base;
        logic [SEQ_W-1:0] nsend;
        logic [SEQ_W-1:0] nnew;
        logic             poll;
        logic             pulse;
    } st_t;

    st_t q, d;
    grant_kind_e kind;

    logic [SEQ_W-1:0] outstanding;
    logic in_rng, skip, ack_take;
    logic ack_run, ack_clr, ack_exp;
    logic poll_run, poll_clr, poll_exp;

    assign outstanding = q.nnew - q.base;

    gbn_ack_window #(.SEQ_W(SEQ_W)) u_win (
        .base_i  (q.base),
        .nsend_i (q.nsend),
        .nnew_i  (q.nnew),
        .num_i   (ack_num_i),
        .accept_o(in_rng),
        .skip_o  (skip)
    );

    assign ack_take = ack_vld_i && in_rng;

    assign ack_run  = (outstanding != '0) && !q.poll;
    assign ack_clr  = ack_take || !ack_run;
    assign poll_run = q.poll;
    assign poll_clr = !q.poll || ack_take;

    gbn_tmr #(.LEN(ACK_TMO)) u_ack_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .run_i(ack_run),
        .clr_i(ack_clr),
        .exp_o(ack_exp)
    );

    gbn_tmr #(.LEN(POLL_TMO)) u_poll_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .run_i(poll_run),
        .clr_i(poll_clr),
        .exp_o(poll_exp)
    );

    always_comb begin
        d       = q;
        d.pulse = ack_exp || poll_exp;
        kind    = GK_NONE;

        if (send_req_i && !ack_vld_i && !q.poll) begin
            if (q.nsend != q.nnew)      kind = GK_RETX;
            else if (outstanding < WIN_V) kind = GK_NEW;
        end

        case (kind)
            GK_RETX: d.nsend = q.nsend + 1'b1;
            GK_NEW: begin
                d.nsend = q.nsend + 1'b1;
                d.nnew  = q.nnew + 1'b1;
            end
            default: ;
        endcase

        if (ack_take) begin
            d.base = ack_num_i;
            if (ack_rej_i || q.poll || skip) d.nsend = ack_num_i;
            d.poll = 1'b0;
        end

        if (ack_exp) d.poll = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign send_gnt_o  = (kind != GK_NONE);
    assign send_seq_o  = q.nsend;
    assign send_retx_o = (kind == GK_RETX);
    assign poll_cmd_o  = q.pulse;

    a_r2_window_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (q.nnew - q.base) <= WIN_V);

    a_r8_hold_in_poll: assert property (@(posedge clk) disable iff (!rst_n)
        q.poll |-> !send_gnt_o);

    a_r10_ack_blocks_gnt: assert property (@(posedge clk) disable iff (!rst_n)
        ack_vld_i |-> !send_gnt_o);

    a_r6_poll_single: assert property (@(posedge clk) disable iff (!rst_n)
        poll_cmd_o |=> !poll_cmd_o);

    a_r4_retx_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (send_gnt_o && send_retx_o) |=> (q.nsend == $past(send_seq_o) + 1'b1));

    a_r5_ignore_base: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_vld_i && !in_rng) |=> (q.base == $past(q.base)));

endmodule

// File: tb/gbn_tx_ctrl_tb.sv
module gbn_tx_ctrl_tb;
    localparam int SEQ_W = 3;
    localparam int WIN = 7;
    localparam int ACK_TMO = 40;
    localparam int POLL_TMO = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic send_req_i = 1'b0;
    logic ack_vld_i = 1'b0;
    logic ack_rej_i = 1'b0;
    logic [SEQ_W-1:0] ack_num_i = '0;
    logic send_gnt_o, send_retx_o, poll_cmd_o;
    logic [SEQ_W-1:0] send_seq_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    int b = 0;

    always #2 clk = ~clk;

    gbn_tx_ctrl #(.SEQ_W(SEQ_W), .WIN(WIN), .ACK_TMO(ACK_TMO), .POLL_TMO(POLL_TMO)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .send_req_i(send_req_i), .send_gnt_o(send_gnt_o),
        .send_seq_o(send_seq_o), .send_retx_o(send_retx_o),
        .ack_vld_i(ack_vld_i), .ack_rej_i(ack_rej_i), .ack_num_i(ack_num_i),
        .poll_cmd_o(poll_cmd_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic grant_one(input bit exp_ok, input int exp_seq, input bit exp_retx, input string req);
        @(negedge clk);
        send_req_i = 1'b1;
        #1;
        chk(send_gnt_o == exp_ok, req, int'(send_gnt_o), int'(exp_ok));
        if (exp_ok && send_gnt_o) begin
            chk(int'(send_seq_o) == exp_seq % 8, req, int'(send_seq_o), exp_seq % 8);
            chk(send_retx_o == exp_retx, req, int'(send_retx_o), int'(exp_retx));
        end
        @(posedge clk);
        #1;
        send_req_i = 1'b0;
    endtask

    task automatic ack(input bit rej, input int num);
        @(negedge clk);
        ack_vld_i = 1'b1;
        ack_rej_i = rej;
        ack_num_i = SEQ_W'(num % 8);
        @(posedge clk);
        #1;
        ack_vld_i = 1'b0;
        ack_rej_i = 1'b0;
    endtask

    task automatic wait_poll(output int n);
        n = 0;
        for (int k = 0; k < 500; k++) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (poll_cmd_o) break;
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                failures++;
                $display("FAIL watchdog act=%0d exp=%0d", cycles, 20000);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R12: reset state, no grant without request, no poll
        chk(!send_gnt_o, "R12 no grant idle", int'(send_gnt_o), 0);
        chk(!poll_cmd_o, "R12 no poll at reset", int'(poll_cmd_o), 0);
        chk(send_seq_o == 0, "R1 first seq", int'(send_seq_o), 0);

        // R1 R2 R3 sweep across all window offsets
        for (int s = 0; s < 8; s++) begin
            for (int i = 0; i < 7; i++) grant_one(1, b + i, 0, "R1 new seq");
            grant_one(0, 0, 0, "R2 full window");
            ack(0, b + 3);
            for (int i = 0; i < 3; i++) grant_one(1, b + 7 + i, 0, "R3 cumulative RR frees");
            grant_one(0, 0, 0, "R2 full after RR");
            ack(0, b + 10);
            grant_one(1, b + 10, 0, "R1 after drain");
            ack(0, b + 11);
            b = (b + 11) % 8;
        end

        // R10: ack cycle withholds grant and consumes no number
        @(negedge clk);
        send_req_i = 1'b1;
        ack_vld_i = 1'b1;
        ack_rej_i = 1'b0;
        ack_num_i = SEQ_W'(b);
        #1;
        chk(!send_gnt_o, "R10 ack blocks grant", int'(send_gnt_o), 0);
        @(posedge clk);
        #1;
        ack_vld_i = 1'b0;
        send_req_i = 1'b0;
        grant_one(1, b, 0, "R10 number not consumed");
        ack(0, b + 1);
        b = (b + 1) % 8;

        // R5: out-of-range acks ignored
        for (int i = 0; i < 3; i++) grant_one(1, b + i, 0, "R1");
        ack(0, b + 5);
        ack(1, b + 6);
        grant_one(1, b + 3, 0, "R5 REJ out of range ignored");
        for (int i = 4; i < 7; i++) grant_one(1, b + i, 0, "R5 window unchanged");
        grant_one(0, 0, 0, "R5 RR out of range ignored");
        ack(0, b + 7);
        b = (b + 7) % 8;

        // R4 REJ rewind, R11 RR skip
        for (int i = 0; i < 5; i++) grant_one(1, b + i, 0, "R1");
        ack(1, b + 2);
        for (int i = 2; i < 5; i++) grant_one(1, b + i, 1, "R4 retransmit");
        grant_one(1, b + 5, 0, "R4 resume new");
        ack(1, b + 3);
        ack(0, b + 5);
        grant_one(1, b + 5, 1, "R11 skip acked");
        grant_one(1, b + 6, 0, "R11 then new");
        ack(0, b + 7);
        b = (b + 7) % 8;

        // R6 R7 R8 R9: timeout, repeated poll, RR response
        grant_one(1, b, 0, "R1");
        wait_poll(n);
        chk(n == ACK_TMO, "R6 ack timeout", n, ACK_TMO);
        wait_poll(n);
        chk(n == POLL_TMO, "R7 poll repeat", n, POLL_TMO);
        grant_one(0, 0, 0, "R8 no grant during poll");
        ack(0, b);
        grant_one(1, b, 1, "R9 RR response rewinds");
        grant_one(1, b + 1, 0, "R9 then new");
        ack(0, b + 2);
        b = (b + 2) % 8;

        // R9 REJ ends poll
        grant_one(1, b, 0, "R1");
        wait_poll(n);
        chk(n == ACK_TMO, "R6 ack timeout again", n, ACK_TMO);
        ack(1, b);
        grant_one(1, b, 1, "R9 REJ ends poll");
        ack(0, b + 1);
        b = (b + 1) % 8;

        // R6 timer restarts on accepted ack
        grant_one(1, b, 0, "R1");
        grant_one(1, b + 1, 0, "R1");
        repeat (25) @(negedge clk);
        ack(0, b + 1);
        wait_poll(n);
        chk(n == ACK_TMO, "R6 restart on progress", n, ACK_TMO);
        ack(0, b + 1);
        grant_one(1, b + 1, 1, "R9 response from oldest");
        ack(0, b + 2);
        b = (b + 2) % 8;

        // R12: long idle, no poll
        n = 0;
        for (int k = 0; k < ACK_TMO + 20; k++) begin
            @(negedge clk);
            if (poll_cmd_o) n++;
        end
        chk(n == 0, "R12 idle no poll", n, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule